// File: doc/BRIEF.md
# Sync Block Inner-Code Encoder

This block assembles one recorded sync block at a time for a helical-scan tape write path. After a start pulse it latches a block identifier and emits it as a two-byte header. It then passes through a 192-byte payload row taken from the outer-coded product array. Last, it appends a 12-byte Reed-Solomon inner parity field that covers both the header and the payload. Every byte of the resulting 206-byte block leaves the block XORed with a whitening sequence. That sequence restarts from a fixed seed at each block, which keeps the count of ones and zeros on tape roughly equal.

Both the payload input and the encoded output are byte-wide valid/ready streams. A stall on the output freezes the parity register, the whitening register and the position counter, so no byte is lost or repeated. The 12 parity bytes give a decoder the power to repair up to 6 corrupted bytes per sync block. That is more than the 5 the recording format needs.

Top module: `syncblk_encoder`

## Requirements
- R1: One accepted start pulse yields exactly 206 output bytes, in three parts: 2 header bytes, then 192 payload bytes, then 12 parity bytes. After the last parity byte, out_valid stays low until the next start pulse.
- R2: The header is the value on blk_id at the accepted start pulse. Bits 15:8 go out first and bits 7:0 second.
- R3: The payload bytes come out in the order they were accepted on the input stream, with no byte dropped or repeated.
- R4: Take the descrambled 206-byte block as a polynomial over GF(2^8), with field polynomial x^8+x^4+x^3+x^2+1 (0x11D). The first byte is the coefficient of the highest degree. This polynomial evaluates to zero at alpha^0 through alpha^11, where alpha = 0x02.
- R5: Every output byte equals its unscrambled byte XOR one mask byte. The mask comes from a 15-bit register with feedback bit s[14]^s[13], shifted in at the bottom. The mask bit is that feedback bit, with the first bit of each byte going to bit 7. The register is loaded with 0x6A3C at every accepted start, and it steps 8 bits per output byte.
- R6: in_ready is low outside the payload part of a block. While the header is being sent, or while idle, a byte offered on the input is not consumed.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value on the next cycle.
- R8: A start pulse that arrives while a block is in progress is ignored. The current block completes with its original header and content, and no new block follows.
- R9: After reset, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_start | input | 1 | Single-cycle request to begin a sync block |
| blk_id | input | 16 | Block identifier sampled with blk_start |
| in_valid | input | 1 | Payload byte present |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte is taken this cycle |
| out_valid | output | 1 | Encoded byte present |
| out_data | output | 8 | Encoded, scrambled byte |
| out_ready | input | 1 | Downstream takes the encoded byte |

## Verification
Output bytes are registered, so a byte accepted on the input, or a header or parity byte selected internally, shows up on out_data one clock after the edge that steps it. The first header byte therefore appears one cycle after the edge that takes the start pulse. In_ready depends combinationally on out_valid and out_ready in the same cycle. The bench drives all inputs at the falling edge and samples one time unit later, which is before the next rising edge. It counts a payload handshake or an output handshake only when both of its signals are high at that sample point, so each transfer is tied to the edge that follows it. A stall is checked on the next sample, which must show the same output byte, and the bench checks idle outputs for several cycles after each block's last byte.

// File: rtl/sbenc_pkg.sv
`timescale 1ns/1ps
package sbenc_pkg;

   localparam int MAX_PAR = 32;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HDR  = 2'd1,
      PH_PAY  = 2'd2,
      PH_PAR  = 2'd3
   } sb_phase_e;

   // GF(2^8) product reduced by the field polynomial
   function automatic logic [7:0] gf_mul(input logic [7:0] a,
                                          input logic [7:0] b,
                                          input logic [8:0] poly);
      logic [7:0] acc;
      logic [7:0] x;
      acc = 8'h00;
      x   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ x;
         x = x[7] ? ((x << 1) ^ poly[7:0]) : (x << 1);
      end
      return acc;
   endfunction

   // Low coefficients of prod (x + alpha^j), j = 0..np-1; leading one dropped
   function automatic logic [8*MAX_PAR-1:0] rs_gen(input int np,
                                                   input logic [8:0] poly);
      logic [7:0] g [0:MAX_PAR];
      logic [7:0] root;
      logic [8*MAX_PAR-1:0] packed_g;
      for (int i = 0; i <= MAX_PAR; i++) g[i] = 8'h00;
      g[0] = 8'h01;
      root = 8'h01;
      for (int j = 0; j < np; j++) begin
         for (int i = np; i >= 1; i--)
            g[i] = g[i-1] ^ gf_mul(g[i], root, poly);
         g[0] = gf_mul(g[0], root, poly);
         root = gf_mul(root, 8'h02, poly);
      end
      packed_g = '0;
      for (int i = 0; i < MAX_PAR; i++)
         if (i < np) packed_g[8*i +: 8] = g[i];
      return packed_g;
   endfunction

endpackage

// File: rtl/sbenc_seq.sv
`timescale 1ns/1ps
module sbenc_seq
   import sbenc_pkg::*;
#(
   parameter int HDR_N = 2,
   parameter int PAY_N = 192,
   parameter int PAR_N = 12,
   localparam int MAXN = (PAY_N > HDR_N) ? ((PAY_N > PAR_N) ? PAY_N : PAR_N)
                                         : ((HDR_N > PAR_N) ? HDR_N : PAR_N),
   localparam int CW   = $clog2(MAXN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            step,
   output sb_phase_e       phase,
   output logic [CW-1:0]   cnt,
   output logic            last
);

   logic [CW-1:0] cur_len;

   always_comb begin
      unique case (phase)
         PH_HDR:  cur_len = CW'(HDR_N);
         PH_PAY:  cur_len = CW'(PAY_N);
         PH_PAR:  cur_len = CW'(PAR_N);
         default: cur_len = CW'(1);
      endcase
      last = (phase != PH_IDLE) && (cnt == cur_len - CW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (go && phase == PH_IDLE) begin
         phase <= PH_HDR;
         cnt   <= '0;
      end else if (step && phase != PH_IDLE) begin
         if (last) begin
            cnt <= '0;
            unique case (phase)
               PH_HDR:  phase <= PH_PAY;
               PH_PAY:  phase <= PH_PAR;
               default: phase <= PH_IDLE;
            endcase
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   // position never leaves the current part of the block
   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |-> (cnt < cur_len));

   // payload is followed by parity only after the full payload count
   assert_pay_to_par_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAY && !step) |=> (phase == PH_PAY));

endmodule

// File: rtl/sbenc_rs.sv
`timescale 1ns/1ps
module sbenc_rs
   import sbenc_pkg::*;
#(
   parameter int         NP   = 12,
   parameter logic [8:0] POLY = 9'h11D
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       feed,
   input  logic       shift,
   input  logic [7:0] din,
   output logic [7:0] par_top,
   output logic       empty
);

   localparam logic [8*MAX_PAR-1:0] GEN = rs_gen(NP, POLY);

   logic [7:0] r   [NP];
   logic [7:0] nxt [NP];
   logic [7:0] fb;

   assign fb      = din ^ r[NP-1];
   assign par_top = r[NP-1];

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         if (feed)
            nxt[i] = ((i == 0) ? 8'h00 : r[(i == 0) ? 0 : i-1])
                     ^ gf_mul(fb, GEN[8*i +: 8], POLY);
         else if (shift)
            nxt[i] = (i == 0) ? 8'h00 : r[(i == 0) ? 0 : i-1];
         else
            nxt[i] = r[i];
      end
      empty = 1'b1;
      for (int i = 0; i < NP; i++)
         if (r[i] != 8'h00) empty = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NP; i++) r[i] <= 8'h00;
      end else if (clr) begin
         for (int i = 0; i < NP; i++) r[i] <= 8'h00;
      end else begin
         for (int i = 0; i < NP; i++) r[i] <= nxt[i];
      end
   end

   // feeding and draining never overlap
   assert_feed_xor_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(feed && shift));

   // a cleared register starts the next block empty
   assert_clear_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

endmodule

// File: rtl/sbenc_scr.sv
`timescale 1ns/1ps
module sbenc_scr #(
   parameter bit          ENABLE = 1'b1,
   parameter logic [14:0] SEED   = 15'h6A3C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       adv,
   output logic [7:0] mask
);

   generate
      if (ENABLE) begin : g_whiten
         logic [14:0] st;
         logic [14:0] nx;
         logic        fbit;

         always_comb begin
            nx   = st;
            mask = 8'h00;
            fbit = 1'b0;
            for (int b = 7; b >= 0; b--) begin
               fbit    = nx[14] ^ nx[13];
               mask[b] = fbit;
               nx      = {nx[13:0], fbit};
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    st <= SEED;
            else if (load) st <= SEED;
            else if (adv)  st <= nx;
         end

         // the whitening register must never lock up at zero
         assert_state_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(st) != 0);

         // a reload lands on the seed
         assert_reload_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (st == SEED));
      end else begin : g_plain
         assign mask = 8'h00;
      end
   endgenerate

endmodule

// File: rtl/syncblk_encoder.sv
`timescale 1ns/1ps
module syncblk_encoder
   import sbenc_pkg::*;
#(
   parameter int          HDR_BYTES = 2,
   parameter int          PAY_BYTES = 192,
   parameter int          PAR_BYTES = 12,
   parameter logic [8:0]  GF_POLY   = 9'h11D,
   parameter bit          WHITEN    = 1'b1,
   parameter logic [14:0] WSEED     = 15'h6A3C,
   localparam int         HDR_W     = 8 * HDR_BYTES,
   localparam int         MAXN      = (PAY_BYTES > HDR_BYTES)
                                      ? ((PAY_BYTES > PAR_BYTES) ? PAY_BYTES : PAR_BYTES)
                                      : ((HDR_BYTES > PAR_BYTES) ? HDR_BYTES : PAR_BYTES),
   localparam int         CW        = $clog2(MAXN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_start,
   input  logic [HDR_W-1:0] blk_id,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   input  logic             out_ready
);

   generate
      if (HDR_BYTES < 1 || PAY_BYTES < 1) begin : g_bad_len
         $error("syncblk_encoder: header and payload need at least one byte");
      end
      if (PAR_BYTES < 1 || PAR_BYTES > MAX_PAR) begin : g_bad_par
         $error("syncblk_encoder: parity length out of range");
      end
      if (HDR_BYTES + PAY_BYTES + PAR_BYTES > 255) begin : g_bad_code
         $error("syncblk_encoder: codeword exceeds 255 bytes");
      end
      if (WSEED == 15'h0000) begin : g_bad_seed
         $error("syncblk_encoder: whitening seed must be nonzero");
      end
   endgenerate

   sb_phase_e       phase;
   logic [CW-1:0]   cnt;
   logic            last;
   logic            adv;
   logic            go;
   logic            step;
   logic [HDR_W-1:0] id_q;
   logic [7:0]      hdr_byte;
   logic [7:0]      par_byte;
   logic [7:0]      raw;
   logic [7:0]      mask;
   logic            rs_empty;

   assign adv      = !out_valid || out_ready;
   assign go       = blk_start && (phase == PH_IDLE);
   assign in_ready = (phase == PH_PAY) && adv;

   always_comb begin
      unique case (phase)
         PH_HDR, PH_PAR: step = adv;
         PH_PAY:         step = adv && in_valid;
         default:        step = 1'b0;
      endcase
   end

   always_comb begin
      hdr_byte = 8'h00;
      for (int k = 0; k < HDR_BYTES; k++)
         if (cnt == CW'(k)) hdr_byte = id_q[8*(HDR_BYTES-1-k) +: 8];
   end

   always_comb begin
      unique case (phase)
         PH_HDR:  raw = hdr_byte;
         PH_PAY:  raw = in_data;
         PH_PAR:  raw = par_byte;
         default: raw = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  id_q <= '0;
      else if (go) id_q <= blk_id;
   end

   sbenc_seq #(
      .HDR_N (HDR_BYTES),
      .PAY_N (PAY_BYTES),
      .PAR_N (PAR_BYTES)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .step  (step),
      .phase (phase),
      .cnt   (cnt),
      .last  (last)
   );

   sbenc_rs #(
      .NP   (PAR_BYTES),
      .POLY (GF_POLY)
   ) u_rs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (go),
      .feed    (step && (phase == PH_HDR || phase == PH_PAY)),
      .shift   (step && (phase == PH_PAR)),
      .din     (raw),
      .par_top (par_byte),
      .empty   (rs_empty)
   );

   sbenc_scr #(
      .ENABLE (WHITEN),
      .SEED   (WSEED)
   ) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (go),
      .adv   (step),
      .mask  (mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= 8'h00;
      end else if (step) begin
         out_valid <= 1'b1;
         out_data  <= raw ^ mask;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // a stalled output byte is held unchanged
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // payload is only taken during the payload part
   assert_ready_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (phase == PH_PAY));

   // parity register is fully drained once the last parity byte leaves
   assert_drained_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAR && step && last) |=> rs_empty);

   // a start during a block changes neither position nor part
   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && blk_start && !step) |=> ($stable(cnt) && $stable(phase)));

   // nothing new is emitted while idle
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && out_valid && out_ready) |=> !out_valid);

endmodule

// File: tb/sim_syncblk_encoder.sv
`timescale 1ns/1ps
module sim_syncblk_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int NPAY = 192;
   localparam int NBLK = 206;
   localparam int NPAR = 12;
   localparam logic [14:0] SEED = 15'h6A3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_start = 1'b0;
   logic [15:0] blk_id = 16'h0000;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_ready = 1'b0;

   int errors = 0;
   int checks = 0;

   logic [7:0] pay  [NPAY];
   logic [7:0] rx   [NBLK];
   logic [7:0] desc [NBLK];

   always #(CLK_PERIOD/2) clk = ~clk;

   syncblk_encoder u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_start (blk_start),
      .blk_id    (blk_id),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready)
   );

   function automatic logic [7:0] tb_gmul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = 16'h0000;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011D << (i - 8));
      return p[7:0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit rdy_pat(input int mode, input int c);
      case (mode)
         0: return 1'b1;
         1: return c[0];
         2: return ((c % 7) != 3) && ((c % 11) != 5);
         default: return ((c / 5) % 2) == 0;
      endcase
   endfunction

   function automatic bit val_pat(input int mode, input int c);
      case (mode)
         0: return 1'b1;
         1: return (c % 3) != 1;
         default: return ((c / 4) % 3) != 2;
      endcase
   endfunction

   task automatic run_block(input logic [15:0] id, input int pat, input int rmode,
                            input int vmode, input bit restart, input int b);
      int sent = 0;
      int got = 0;
      int cyc = 0;
      bit prev_stall = 1'b0;
      logic [7:0] prev_data = 8'h00;
      logic [14:0] s;
      logic [7:0] syn;
      logic [7:0] a;

      for (int i = 0; i < NPAY; i++) begin
         case (pat)
            0: pay[i] = 8'h00;
            1: pay[i] = 8'(i);
            2: pay[i] = 8'hFF;
            3: pay[i] = 8'((i * 37 + b * 11) ^ (i >> 3));
            default: pay[i] = (i == (b * 37) % NPAY) ? (8'h80 >> (b % 8)) : 8'h00;
         endcase
      end

      @(negedge clk);
      blk_start = 1'b1;
      blk_id    = id;
      in_valid  = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      blk_start = 1'b0;

      while (got < NBLK && cyc < 4000) begin
         out_ready = rdy_pat(rmode, cyc);
         blk_start = restart && (cyc == 40);
         blk_id    = (restart && cyc == 40) ? ~id : id;
         if (sent < NPAY && val_pat(vmode, cyc)) begin
            in_valid = 1'b1;
            in_data  = pay[sent];
         end else begin
            in_valid = 1'b0;
            in_data  = 8'hA5;
         end
         #1;
         if (prev_stall)
            check(out_valid && out_data == prev_data, "R7", "stalled byte held",
                  int'(out_data), int'(prev_data));
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         if (in_valid && in_ready) sent++;
         if (out_valid && out_ready) begin
            rx[got] = out_data;
            got++;
         end
         @(negedge clk);
         cyc++;
      end
      blk_start = 1'b0;
      in_valid  = 1'b0;
      if (cyc >= 4000) check(1'b0, "R1", "block timeout bytes", got, NBLK);
      check(sent == NPAY, "R3", "payload bytes consumed", sent, NPAY);

      // descramble with an independent whitening model (R5)
      s = SEED;
      for (int k = 0; k < NBLK; k++) begin
         logic [7:0] m;
         m = 8'h00;
         for (int bt = 7; bt >= 0; bt--) begin
            logic f;
            f = s[14] ^ s[13];
            m[bt] = f;
            s = {s[13:0], f};
         end
         desc[k] = rx[k] ^ m;
      end

      check(desc[0] == id[15:8], "R2", "header high byte (R5 descrambled)",
            int'(desc[0]), int'(id[15:8]));
      check(desc[1] == id[7:0], "R2", "header low byte (R5 descrambled)",
            int'(desc[1]), int'(id[7:0]));
      for (int i = 0; i < NPAY; i++)
         check(desc[2 + i] == pay[i], "R3", $sformatf("payload byte %0d (R5)", i),
               int'(desc[2 + i]), int'(pay[i]));

      // codeword must vanish at alpha^0..alpha^11 (R4)
      a = 8'h01;
      for (int j = 0; j < NPAR; j++) begin
         syn = 8'h00;
         for (int k = 0; k < NBLK; k++) syn = tb_gmul(syn, a) ^ desc[k];
         check(syn == 8'h00, "R4", $sformatf("syndrome %0d", j), int'(syn), 0);
         a = tb_gmul(a, 8'h02);
      end

      // after the block: no extra byte, no payload taken (R1, R6, R8)
      for (int c = 0; c < 6; c++) begin
         out_ready = 1'b1;
         in_valid  = 1'b1;
         in_data   = 8'h5A;
         #1;
         check(!out_valid, "R1", "no byte after block end", int'(out_valid), 0);
         check(!in_ready, "R6", "idle input not ready", int'(in_ready), 0);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(!out_valid, "R9", "out_valid in reset", int'(out_valid), 0);
      check(!in_ready, "R9", "in_ready in reset", int'(in_ready), 0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b1;
      in_data  = 8'h33;
      out_ready = 1'b1;
      #1;
      check(!out_valid, "R9", "out_valid after reset", int'(out_valid), 0);
      check(!in_ready, "R6", "in_ready idle after reset", int'(in_ready), 0);
      @(negedge clk);
      in_valid = 1'b0;

      for (int b = 0; b < 12; b++) begin
         logic [15:0] id;
         id = (b == 0) ? 16'h0000 : (16'h1234 * 16'(b)) ^ 16'h0F0F;
         // blocks 5 and 9 carry a start pulse mid-block (R8)
         run_block(id, b % 5, b % 4, (b / 2) % 3, (b == 5) || (b == 9), b);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule